// File: doc/BRIEF.md
# Bursty On-Off Cell Source

This block produces the per-slot cell arrivals of one switch input under a two-state bursty traffic law. In every slot it is either inside a burst, emitting exactly one cell, or inside a gap, emitting nothing. All cells of one burst go to the same output port. A fresh port is drawn when a burst begins and is kept until the burst is over. The length of each burst and of each gap is geometric. Each length is decided slot by slot: a pseudo-random 16-bit sample is compared against a programmable end threshold. A burst always holds at least one cell. A gap may last zero slots, in which case a new burst follows straight after the last cell of the previous one. The mean burst is 1/p slots and the offered load is q/(q + p - pq), where p and q are the threshold values divided by 65536.

A comparison mode produces uniform Bernoulli traffic instead. In this mode each slot independently carries a cell with a programmable probability, and each cell's port is drawn uniformly. Two seeded 32-bit generators supply the randomness. One feeds the period and arrival decisions and the other feeds the port draw. A slot strobe paces everything, so the source can run at any fraction of the clock rate.

States: `ST_IDLE` (in a gap), `ST_BURST` (the last slot carried a burst cell), `ST_UNIF` (Bernoulli mode). Transitions: start (`ST_IDLE`/`ST_UNIF` to `ST_BURST`), stay-idle (to `ST_IDLE`), continue (`ST_BURST` to `ST_BURST`, same port), restart (`ST_BURST` to `ST_BURST` with a new port, zero-length gap), finish (`ST_BURST` to `ST_IDLE`), and enter-uniform (any state to `ST_UNIF` while the mode input is high).

Top module: `onoff_cell_src`

## Requirements
- R1: A synchronous reset clears `cell_vld` and `cell_dst` to 0 and enters `ST_IDLE`. It loads the decision generator with `seed`, and the port generator with `seed ^ 32'h9E3779B9`. Either value that would be zero is replaced by 1.
- R2: Outputs, state and both generators change only in cycles where `slot` is high. Each slot, each generator advances 32 steps of a right-shifting Galois LFSR with tap mask `32'h80200003` (shift right; if the bit shifted out was 1, XOR the mask in). The word used in a slot is the generator value before that slot's advance.
- R3: In bursty mode from `ST_IDLE` or `ST_UNIF`, a cell is emitted and `ST_BURST` is entered when the decision word bits [31:16] are strictly below `idle_end_thr`. Otherwise no cell is emitted and the state is `ST_IDLE`; a threshold of 0 never starts a burst.
- R4: In `ST_BURST`, when decision bits [15:0] are not below `act_end_thr`, another cell is emitted with the port unchanged.
- R5: In `ST_BURST`, when decision bits [15:0] are below `act_end_thr`, the burst is over. If bits [31:16] are below `idle_end_thr` in the same slot, a new burst starts at once with a newly drawn port. Otherwise no cell is emitted and the state becomes `ST_IDLE`.
- R6: A newly drawn port comes from the port generator's word, cut into fields of W = clog2(N_PORTS) bits. Field i is bits [i*W +: W], for i from 0 while (i+1)*W <= 32. The first field below N_PORTS is used. If no field qualifies, field 0 shifted right by one is used.
- R7: While `bern_mode` is high, the state is `ST_UNIF`. A cell is emitted in a slot exactly when decision bits [15:0] are below `bern_thr`, and each such cell gets a newly drawn port.
- R8: In any slot without a cell, `cell_dst` keeps its previous value.
- R9: `cell_dst` is always below N_PORTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot | input | 1 | Slot strobe; one traffic decision per high cycle |
| bern_mode | input | 1 | 1 selects uniform Bernoulli arrivals |
| seed | input | 32 | Generator seed loaded at reset |
| act_end_thr | input | 16 | Burst end probability times 65536 |
| idle_end_thr | input | 16 | Gap end probability times 65536 |
| bern_thr | input | 16 | Bernoulli arrival probability times 65536 |
| cell_vld | output | 1 | A cell arrives in this slot |
| cell_dst | output | clog2(N_PORTS) | Output port of the cell |

## Verification
The bench drives the ends of the threshold range. With the burst end threshold at 0 the burst must never break, which catches a design that redraws the port on every cell. With both thresholds at the maximum, bursts must chain with no gap, which catches a design that always forces one empty slot after a burst. With the gap threshold at 0 the line must go silent. A second instance with five ports exercises the rejection draw, where accepting an out-of-range field, or picking the wrong one, shows up as a wrong or illegal port. Gaps in the slot strobe, a zero seed and switches in and out of Bernoulli mode catch generators that run every clock, a generator that locks up at zero, and stale state left over after the uniform mode.

// File: rtl/onoff_pkg.sv
package onoff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_UNIF  = 2'd2
    } src_state_t;

    localparam int          GEN_W      = 32;
    localparam int          GEN_STEPS  = 32;
    localparam int          SAMP_W     = 16;
    localparam logic [31:0] GEN_TAPS   = 32'h8020_0003;
    localparam logic [31:0] DEST_SALT  = 32'h9E37_79B9;

endpackage

// File: rtl/onoff_lfsr.sv
module onoff_lfsr #(
    parameter int          W     = 32,
    parameter int          STEPS = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] seed,
    output logic [W-1:0] word
);

    logic [W-1:0] gen_q;
    logic [W-1:0] gen_nxt;

    always_comb begin
        gen_nxt = gen_q;
        for (int i = 0; i < STEPS; i++) begin
            gen_nxt = {1'b0, gen_nxt[W-1:1]} ^ (gen_nxt[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= (seed == '0) ? W'(1) : seed;
        end else if (adv) begin
            gen_q <= gen_nxt;
        end
    end

    assign word = gen_q;

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        gen_q != '0); // R1

    AST_GEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(gen_q)); // R2

endmodule

// File: rtl/onoff_dest_pick.sv
module onoff_dest_pick #(
    parameter int unsigned N_PORTS = 8,
    parameter int          WORD_W  = 32,
    localparam int         DW      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int         NCAND   = WORD_W / DW
) (
    input  logic [WORD_W-1:0] word,
    output logic [DW-1:0]     port
);

    logic [DW-1:0] cand [NCAND];
    logic [NCAND-1:0] fits;

    for (genvar i = 0; i < NCAND; i++) begin : g_cand
        assign cand[i] = word[i*DW +: DW];
        assign fits[i] = 32'(cand[i]) < N_PORTS;
    end

    always_comb begin
        port = cand[0] >> 1;
        for (int i = NCAND - 1; i >= 0; i--) begin
            if (fits[i]) begin
                port = cand[i];
            end
        end
    end

    logic unused_bits;
    assign unused_bits = ^word;

    always_comb begin
        AST_PICK_RANGE: assert (32'(port) < N_PORTS); // R6
    end

endmodule

// File: rtl/onoff_cell_src.sv
module onoff_cell_src
    import onoff_pkg::*;
#(
    parameter int unsigned N_PORTS = 8,
    localparam int         DST_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot,
    input  logic             bern_mode,
    input  logic [31:0]      seed,
    input  logic [15:0]      act_end_thr,
    input  logic [15:0]      idle_end_thr,
    input  logic [15:0]      bern_thr,
    output logic             cell_vld,
    output logic [DST_W-1:0] cell_dst
);

    logic [GEN_W-1:0] dec_word;
    logic [GEN_W-1:0] dst_word;
    logic [DST_W-1:0] new_port;
    logic [SAMP_W-1:0] samp_a;
    logic [SAMP_W-1:0] samp_b;

    onoff_lfsr #(.W(GEN_W), .STEPS(GEN_STEPS), .TAPS(GEN_TAPS)) u_dec_gen (
        .clk  (clk),
        .rst  (rst),
        .adv  (slot),
        .seed (seed),
        .word (dec_word)
    );

    onoff_lfsr #(.W(GEN_W), .STEPS(GEN_STEPS), .TAPS(GEN_TAPS)) u_dst_gen (
        .clk  (clk),
        .rst  (rst),
        .adv  (slot),
        .seed (seed ^ DEST_SALT),
        .word (dst_word)
    );

    onoff_dest_pick #(.N_PORTS(N_PORTS), .WORD_W(GEN_W)) u_pick (
        .word (dst_word),
        .port (new_port)
    );

    assign samp_a = dec_word[SAMP_W-1:0];
    assign samp_b = dec_word[GEN_W-1:SAMP_W];

    logic act_end, idle_end, bern_hit;
    assign act_end  = samp_a < act_end_thr;
    assign idle_end = samp_b < idle_end_thr;
    assign bern_hit = samp_a < bern_thr;

    src_state_t state_q, state_nxt;
    logic             vld_nxt;
    logic [DST_W-1:0] dst_nxt;

    always_comb begin
        state_nxt = state_q;
        vld_nxt   = 1'b0;
        dst_nxt   = cell_dst;
        if (bern_mode) begin
            state_nxt = ST_UNIF;               // enter-uniform
            vld_nxt   = bern_hit;
            if (bern_hit) dst_nxt = new_port;
        end else begin
            unique case (state_q)
                ST_BURST: begin
                    if (!act_end) begin            // continue
                        vld_nxt   = 1'b1;
                        state_nxt = ST_BURST;
                    end else if (idle_end) begin   // restart
                        vld_nxt   = 1'b1;
                        dst_nxt   = new_port;
                        state_nxt = ST_BURST;
                    end else begin                 // finish
                        state_nxt = ST_IDLE;
                    end
                end
                ST_IDLE, ST_UNIF: begin
                    if (idle_end) begin            // start
                        vld_nxt   = 1'b1;
                        dst_nxt   = new_port;
                        state_nxt = ST_BURST;
                    end else begin                 // stay-idle
                        state_nxt = ST_IDLE;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (slot) begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_vld <= 1'b0;
            cell_dst <= '0;
        end else if (slot) begin
            cell_vld <= vld_nxt;
            cell_dst <= dst_nxt;
        end
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot |=> $stable(cell_vld) && $stable(cell_dst)); // R2

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (slot && !bern_mode && state_q != ST_BURST && samp_b >= idle_end_thr)
        |=> !cell_vld); // R3

    AST_BURST_KEEP_DST: assert property (@(posedge clk) disable iff (rst)
        (slot && !bern_mode && state_q == ST_BURST && samp_a >= act_end_thr)
        |=> cell_vld && $stable(cell_dst)); // R4

    AST_BERN_MISS: assert property (@(posedge clk) disable iff (rst)
        (slot && bern_mode && samp_a >= bern_thr)
        |=> !cell_vld && $stable(cell_dst)); // R7

    AST_DST_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cell_dst) < N_PORTS); // R9

endmodule

// File: tb/sim_onoff_cell_src.sv
`timescale 1ns/1ps
module sim_onoff_cell_src;

    localparam logic [31:0] TAPS = 32'h8020_0003;
    localparam logic [31:0] SALT = 32'h9E37_79B9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot = 1'b0;
    logic        bern_mode = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    logic [15:0] act_end_thr = 16'h0;
    logic [15:0] idle_end_thr = 16'h0;
    logic [15:0] bern_thr = 16'h0;
    logic        vld0, vld1;
    logic [2:0]  dst0, dst1;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    onoff_cell_src #(.N_PORTS(8)) u0 (
        .clk(clk), .rst(rst), .slot(slot), .bern_mode(bern_mode), .seed(seed),
        .act_end_thr(act_end_thr), .idle_end_thr(idle_end_thr), .bern_thr(bern_thr),
        .cell_vld(vld0), .cell_dst(dst0));

    onoff_cell_src #(.N_PORTS(5)) u1 (
        .clk(clk), .rst(rst), .slot(slot), .bern_mode(bern_mode), .seed(seed),
        .act_end_thr(act_end_thr), .idle_end_thr(idle_end_thr), .bern_thr(bern_thr),
        .cell_vld(vld1), .cell_dst(dst1));

    // reference model state per instance: [0] eight ports, [1] five ports
    logic [31:0] m_r [2];
    logic [31:0] m_d [2];
    bit          m_burst [2];
    bit          m_v [2];
    int          m_dst [2];

    function automatic logic [31:0] gen_adv(logic [31:0] x);
        for (int i = 0; i < 32; i++) x = (x >> 1) ^ (x[0] ? TAPS : 32'h0);
        return x;
    endfunction

    function automatic int pick(logic [31:0] d, int n, int w);
        int m = (1 << w) - 1;
        for (int i = 0; i < 32 / w; i++) begin
            int c = int'((d >> (i * w)) & m);
            if (c < n) return c;
        end
        return int'(d & m) >> 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_r[k] = (seed == 0) ? 32'h1 : seed;                  // R1
            m_d[k] = ((seed ^ SALT) == 0) ? 32'h1 : (seed ^ SALT);
            m_burst[k] = 0; m_v[k] = 0; m_dst[k] = 0;
        end
    endtask

    // one slot of the expected behaviour; returns the requirement tags
    task automatic model_slot(input int k, output string rv, output string rd);
        int n = (k == 0) ? 8 : 5;
        int a = int'(m_r[k][15:0]);
        int b = int'(m_r[k][31:16]);
        int np = pick(m_d[k], n, 3);
        rd = "R8";
        if (bern_mode) begin
            rv = "R7"; m_burst[k] = 0;
            m_v[k] = a < int'(bern_thr);
            if (m_v[k]) begin m_dst[k] = np; rd = "R6"; end
        end else if (m_burst[k] && a >= int'(act_end_thr)) begin
            rv = "R4"; rd = "R4"; m_v[k] = 1;
        end else if (m_burst[k]) begin
            rv = "R5";
            if (b < int'(idle_end_thr)) begin
                m_v[k] = 1; m_dst[k] = np; rd = "R6";
            end else begin
                m_v[k] = 0; m_burst[k] = 0;
            end
        end else begin
            rv = "R3";
            if (b < int'(idle_end_thr)) begin
                m_v[k] = 1; m_burst[k] = 1; m_dst[k] = np; rd = "R6";
            end else m_v[k] = 0;
        end
        m_r[k] = gen_adv(m_r[k]);
        m_d[k] = gen_adv(m_d[k]);
    endtask

    task automatic compare_all(input string rv0, input string rd0,
                               input string rv1, input string rd1);
        check(vld0 == m_v[0], rv0, "u0 cell_vld", int'(vld0), int'(m_v[0]));
        check(int'(dst0) == m_dst[0], rd0, "u0 cell_dst", int'(dst0), m_dst[0]);
        check(vld1 == m_v[1], rv1, "u1 cell_vld", int'(vld1), int'(m_v[1]));
        check(int'(dst1) == m_dst[1], rd1, "u1 cell_dst", int'(dst1), m_dst[1]);
        check(int'(dst1) < 5, "R9", "u1 port range", int'(dst1), 4);
    endtask

    task automatic do_reset(input logic [31:0] s);
        @(negedge clk);
        rst = 1; slot = 1; seed = s;
        @(negedge clk);
        @(negedge clk);
        rst = 0; slot = 0;
        model_reset();
        check(vld0 == 0 && vld1 == 0, "R1", "vld after reset", int'(vld0 | vld1), 0);
        check(dst0 == 0 && dst1 == 0, "R1", "dst after reset", int'(dst0 | dst1), 0);
    endtask

    task automatic run(input int cycles, input int slot_pct, input bit bm,
                       input logic [15:0] pa, input logic [15:0] pi,
                       input logic [15:0] pb);
        string rv0, rd0, rv1, rd1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            slot = ($urandom % 100) < slot_pct;
            bern_mode = bm; act_end_thr = pa; idle_end_thr = pi; bern_thr = pb;
            @(posedge clk);
            #1;
            if (slot) begin
                model_slot(0, rv0, rd0);
                model_slot(1, rv1, rd1);
            end else begin
                rv0 = "R2"; rd0 = "R2"; rv1 = "R2"; rd1 = "R2";
            end
            compare_all(rv0, rd0, rv1, rd1);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset(32'h1234_5678);
        run(400, 70, 0, 16'h2000, 16'h3000, 16'h0);   // mixed bursts
        run(200, 60, 0, 16'h0000, 16'hFFFF, 16'h0);   // R4: bursts never end
        run(200, 80, 0, 16'hFFFF, 16'hFFFF, 16'h0);   // R5: back-to-back bursts
        run(150, 80, 0, 16'hFFFF, 16'h0000, 16'h0);   // R3: line goes quiet
        run(300, 70, 1, 16'h0, 16'h0, 16'h8000);      // R7: uniform arrivals
        run(300, 70, 0, 16'h4000, 16'h1000, 16'h0);   // leave uniform mode
        for (int ph = 0; ph < 8; ph++) begin
            run(200, 50 + int'($urandom % 50), ($urandom % 3) == 0,
                16'($urandom), 16'($urandom), 16'($urandom));
        end
        do_reset(32'h0);                                // R1 zero seed
        run(300, 90, 0, 16'h3000, 16'h5000, 16'h0);
        do_reset(SALT);                                 // R1 zero port seed
        run(300, 90, 1, 16'h0, 16'h0, 16'hC000);
        summary();
    end

endmodule